// File: doc/BRIEF.md
# Segment Translation Unit with Descriptor Checks

This block turns a processor's logical address into a physical address through a small set of segment descriptors held inside it. Each access arrives as a request carrying the logical address, the kind of access (data read, data write, instruction fetch or stack reference) and whether the processor runs in supervisor state. The top bits of the address select a segment number. All descriptors are compared at once. The winning descriptor supplies a base that is added to the in-segment offset. It also supplies a length limit and permission bits, and the block checks the access against both.

Two plain control inputs turn translation on and off and pick the segment granularity. In the coarse mode a segment number has 3 bits and there are 8 large segments. In the fine mode it has 7 bits and there are 128 smaller segments. When a check fails, the response carries a fault strobe. A status byte records the cause and the permission bits of the descriptor at fault. It keeps the first fault until software clears it.

Requests and responses use valid/ready handshakes with a single response register between them. A request is taken only when the response register is empty or is being drained in the same cycle. The consumer can therefore hold `rsp_ready` low for as long as it likes. While it does so, the response stays put and no new request is accepted. Descriptors are loaded whole through a plain write port.

Top module: `mmu_seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `stat` is 0, `req_ready` is 1 and every descriptor is invalid.
- R2: `cfg_we` writes all fields of descriptor `cfg_idx`, and the write takes effect on the next clock. `cfg_attr` holds, from bit 5 down to bit 0: present, supervisor-only, executable, readable, writable, stack.
- R3: With `ctl_enable`=0, a response returns `rsp_paddr` equal to the request's logical address and `rsp_fault`=0, and `stat` does not change.
- R4: With `ctl_seg128`=1, the segment number is logical address bits [23:17] and is compared with all 7 stored bits. The offset is bits [16:0]. The physical address is base*256 plus the offset.
- R5: With `ctl_seg128`=0, only address bits [23:21] are compared, against the top 3 stored segment bits. The offset is bits [20:0].
- R6: When several valid descriptors match, the one with the lowest index is used.
- R7: The result is not present when no descriptor with its valid flag set matches, or when the matching descriptor's present bit is 0. This faults, and a captured status is exactly 0x80.
- R8: The offset divided by 256 may equal the stored length field without a fault. One more than the length field raises a length violation.
- R9: An access error is raised when `req_super`=0 touches a supervisor-only segment. It is also raised when the needed permission is missing. `req_acc` selects the permission: 0 read needs readable, 1 write needs writable, 2 fetch needs executable, 3 stack needs readable and writable.
- R10: The `stat` bits are: [7] not present, [6] fault in a stack segment, [5] length violation, [4] access error, and [3:0] the faulting descriptor's supervisor-only, executable, readable and writable bits.
- R11: `stat` captures the first fault and holds it through later faults. A one-cycle `stat_clr` clears it back to 0.
- R12: A faulting response has `rsp_paddr`=0 and `rsp_fault`=1.
- R13: Each accepted request yields exactly one response one clock later. While `rsp_valid`=1 and `rsp_ready`=0, the response stays stable and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Translation and checking on |
| ctl_seg128 | input | 1 | 1: 128 segments, 0: 8 segments |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 3 | Descriptor slot to write |
| cfg_attr | input | 6 | Attribute bits (see R2) |
| cfg_len | input | 11 | Segment length in 256-byte units, minus one |
| cfg_seg_valid | input | 1 | Descriptor valid flag |
| cfg_seg | input | 7 | Left-justified segment number |
| cfg_base | input | 14 | Physical base in 256-byte units |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_laddr | input | 24 | Logical address |
| req_acc | input | 2 | Access kind (see R9) |
| req_super | input | 1 | Supervisor state |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 24 | Physical address |
| rsp_fault | output | 1 | Access faulted |
| stat_clr | input | 1 | Clear fault status |
| stat | output | 8 | Captured fault status (see R10) |

## Verification
The assertions assume a few things about the block's inputs. The control inputs and the descriptor set stay constant while a request sits in the response register. `stat_clr` is a short pulse, not a level held during fault traffic. The consumer may stall for any length of time. The stimulus programs descriptors and control inputs only while no response is pending. It clears status on idle cycles and presents one request at a time. Back-pressure is exercised by a multi-cycle stall.

// File: rtl/mmu_seg_pkg.sv
package mmu_seg_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_STACK = 2'd3
  } acc_e;

  typedef struct packed {
    logic present;
    logic sup;
    logic exe;
    logic rd;
    logic wr;
    logic stack;
  } attr_t;
endpackage

// File: rtl/mmu_seg_desc.sv
module mmu_seg_desc
  import mmu_seg_pkg::*;
#(
  parameter int N      = 8,
  parameter int SEG_W  = 7,
  parameter int LEN_W  = 11,
  parameter int BASE_W = 14,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  attr_t                        wr_attr,
  input  logic [LEN_W-1:0]             wr_len,
  input  logic                         wr_sv,
  input  logic [SEG_W-1:0]             wr_seg,
  input  logic [BASE_W-1:0]            wr_base,
  output attr_t [N-1:0]                attr_o,
  output logic  [N-1:0][LEN_W-1:0]     len_o,
  output logic  [N-1:0]                sv_o,
  output logic  [N-1:0][SEG_W-1:0]     seg_o,
  output logic  [N-1:0][BASE_W-1:0]    base_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        attr_o[g] <= '0;
        len_o[g]  <= '0;
        sv_o[g]   <= 1'b0;
        seg_o[g]  <= '0;
        base_o[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        attr_o[g] <= wr_attr;
        len_o[g]  <= wr_len;
        sv_o[g]   <= wr_sv;
        seg_o[g]  <= wr_seg;
        base_o[g] <= wr_base;
      end
    end
  end
endmodule

// File: rtl/mmu_seg_match.sv
module mmu_seg_match #(
  parameter int N        = 8,
  parameter int SEG_W    = 7,
  parameter int NARROW_W = 3,
  localparam int IDX_W   = $clog2(N)
) (
  input  logic [SEG_W-1:0]          seg_in,
  input  logic                      fine,
  input  logic [N-1:0]              sv,
  input  logic [N-1:0][SEG_W-1:0]   seg,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx
);
  localparam logic [SEG_W-1:0] MASK_COARSE =
    {{NARROW_W{1'b1}}, {(SEG_W-NARROW_W){1'b0}}};

  logic [SEG_W-1:0] mask;
  logic [N-1:0]     eq;

  assign mask = fine ? {SEG_W{1'b1}} : MASK_COARSE;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = sv[g] && (((seg[g] ^ seg_in) & mask) == '0);
  end

  // lowest index wins: scan from the top so lower slots overwrite
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mmu_seg_check.sv
module mmu_seg_check
  import mmu_seg_pkg::*;
#(
  parameter int LADDR_W = 24,
  parameter int OFF_W   = 21,
  parameter int LEN_W   = 11,
  parameter int BASE_W  = 14,
  parameter int UNIT_SH = 8
) (
  input  attr_t               attr,
  input  logic [LEN_W-1:0]    len,
  input  logic [BASE_W-1:0]   base,
  input  logic [OFF_W-1:0]    offset,
  input  acc_e                acc,
  input  logic                super_st,
  output logic                len_err,
  output logic                acc_err,
  output logic [LADDR_W-1:0]  paddr
);
  logic [OFF_W-1:0] units;
  logic             perm;

  assign units   = offset >> UNIT_SH;
  assign len_err = units > OFF_W'(len);

  always_comb begin
    unique case (acc)
      ACC_READ:  perm = attr.rd;
      ACC_WRITE: perm = attr.wr;
      ACC_FETCH: perm = attr.exe;
      default:   perm = attr.rd & attr.wr;
    endcase
  end

  assign acc_err = (attr.sup && !super_st) || !perm;
  assign paddr   = (LADDR_W'(base) << UNIT_SH) + LADDR_W'(offset);
endmodule

// File: rtl/mmu_seg_xlate.sv
module mmu_seg_xlate
  import mmu_seg_pkg::*;
#(
  parameter int N        = 8,
  parameter int LADDR_W  = 24,
  parameter int SEG_W    = 7,
  parameter int NARROW_W = 3,
  parameter int LEN_W    = 11,
  parameter int BASE_W   = 14,
  parameter int UNIT_SH  = 8,
  localparam int IDX_W   = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_enable,
  input  logic               ctl_seg128,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [5:0]         cfg_attr,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_seg_valid,
  input  logic [SEG_W-1:0]   cfg_seg,
  input  logic [BASE_W-1:0]  cfg_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LADDR_W-1:0] req_laddr,
  input  logic [1:0]         req_acc,
  input  logic               req_super,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [LADDR_W-1:0] rsp_paddr,
  output logic               rsp_fault,
  input  logic               stat_clr,
  output logic [7:0]         stat
);
  localparam int OFF_WIDE   = LADDR_W - NARROW_W;
  localparam int OFF_NARROW = LADDR_W - SEG_W;

  attr_t [N-1:0]              d_attr;
  logic  [N-1:0][LEN_W-1:0]   d_len;
  logic  [N-1:0]              d_sv;
  logic  [N-1:0][SEG_W-1:0]   d_seg;
  logic  [N-1:0][BASE_W-1:0]  d_base;

  mmu_seg_desc #(.N(N), .SEG_W(SEG_W), .LEN_W(LEN_W), .BASE_W(BASE_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_attr(attr_t'(cfg_attr)), .wr_len(cfg_len), .wr_sv(cfg_seg_valid),
    .wr_seg(cfg_seg), .wr_base(cfg_base),
    .attr_o(d_attr), .len_o(d_len), .sv_o(d_sv), .seg_o(d_seg), .base_o(d_base)
  );

  logic             hit;
  logic [IDX_W-1:0] sel;

  mmu_seg_match #(.N(N), .SEG_W(SEG_W), .NARROW_W(NARROW_W)) u_match (
    .seg_in(req_laddr[LADDR_W-1 -: SEG_W]), .fine(ctl_seg128),
    .sv(d_sv), .seg(d_seg), .hit(hit), .idx(sel)
  );

  attr_t               s_attr;
  logic [OFF_WIDE-1:0] offset;
  logic                len_err, acc_err;
  logic [LADDR_W-1:0]  xl_paddr;

  assign s_attr = d_attr[sel];
  assign offset = ctl_seg128 ? OFF_WIDE'(req_laddr[OFF_NARROW-1:0])
                             : req_laddr[OFF_WIDE-1:0];

  mmu_seg_check #(.LADDR_W(LADDR_W), .OFF_W(OFF_WIDE), .LEN_W(LEN_W),
                  .BASE_W(BASE_W), .UNIT_SH(UNIT_SH)) u_check (
    .attr(s_attr), .len(d_len[sel]), .base(d_base[sel]), .offset(offset),
    .acc(acc_e'(req_acc)), .super_st(req_super),
    .len_err(len_err), .acc_err(acc_err), .paddr(xl_paddr)
  );

  logic       absent, fault_now, accept;
  logic [7:0] cause;

  assign absent    = !hit || !s_attr.present;
  assign fault_now = ctl_enable && (absent || len_err || acc_err);
  assign cause     = absent ? 8'h80
                   : {1'b0, s_attr.stack, len_err, acc_err,
                      s_attr.sup, s_attr.exe, s_attr.rd, s_attr.wr};

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= fault_now;
      rsp_paddr <= !ctl_enable ? req_laddr : (fault_now ? '0 : xl_paddr);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
    end else if (stat_clr) begin
      stat <= (accept && fault_now) ? cause : 8'h00;
    end else if (stat == 8'h00 && accept && fault_now) begin
      stat <= cause;
    end
  end
endmodule

// File: rtl/mmu_seg_xlate_chk.sv
module mmu_seg_xlate_chk #(
  parameter int LADDR_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctl_enable,
  input logic               req_valid,
  input logic               req_ready,
  input logic [LADDR_W-1:0] req_laddr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [LADDR_W-1:0] rsp_paddr,
  input logic               rsp_fault,
  input logic               stat_clr,
  input logic [7:0]         stat
);
  // R13: stalled response is held and blocks new requests
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
  a_r13_block: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R13: an accepted request always produces a response next cycle
  a_r13_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R3: translation off gives the logical address back without fault
  a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ctl_enable) |=>
      (!rsp_fault && rsp_paddr == $past(req_laddr)));
  // R12: faulting responses carry a zero address
  a_r12_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
  // R11: captured status holds until cleared
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != 8'h00 && !stat_clr) |=> $stable(stat));
  // R7: not-present status carries no other bit
  a_r7_absent_only: assert property (@(posedge clk) disable iff (!rst_n)
    stat[7] |-> (stat[6:0] == 7'h00));
  // R11: status never appears without an accepted request
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 8'h00 && !(req_valid && req_ready)) |=> (stat == 8'h00));
endmodule

bind mmu_seg_xlate mmu_seg_xlate_chk #(.LADDR_W(LADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable),
  .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .stat_clr(stat_clr), .stat(stat)
);

// File: tb/tb_mmu_seg_xlate.sv
module tb_mmu_seg_xlate;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_enable = 1'b0, ctl_seg128 = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [5:0]  cfg_attr = '0;
  logic [10:0] cfg_len = '0;
  logic        cfg_seg_valid = 1'b0;
  logic [6:0]  cfg_seg = '0;
  logic [13:0] cfg_base = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [23:0] req_laddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_super = 1'b0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [23:0] rsp_paddr;
  logic        rsp_fault;
  logic        stat_clr = 1'b0;
  logic [7:0]  stat;

  int n_chk = 0, n_bad = 0;
  logic [23:0] got_pa;
  logic        got_f, got_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_seg_xlate dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_desc(int idx, logic [5:0] attr, logic [10:0] len,
                         logic sv, logic [6:0] seg, logic [13:0] base);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_attr = attr; cfg_len = len;
    cfg_seg_valid = sv; cfg_seg = seg; cfg_base = base;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(logic [23:0] la, logic [1:0] acc, logic sup);
    @(negedge clk);
    req_valid = 1'b1; req_laddr = la; req_acc = acc; req_super = sup;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_v = rsp_valid; got_pa = rsp_paddr; got_f = rsp_fault;
  endtask

  task automatic clear_stat();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  // attr bits: present sup exe rd wr stack
  task automatic t_reset();
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 stat", stat, 0);
    check("R1 req_ready", req_ready, 1);
    ctl_enable = 1'b1;
    access(24'h0A0A34, 2'd0, 1'b1);
    check("R1 no descriptor valid -> absent", stat, 8'h80);
    ctl_enable = 1'b0;
    clear_stat();
  endtask

  task automatic t_disabled();
    ctl_enable = 1'b0;
    access(24'hABCDEF, 2'd1, 1'b0);
    check("R3 paddr", got_pa, 24'hABCDEF);
    check("R3 fault", got_f, 0);
    check("R3 stat untouched", stat, 0);
  endtask

  task automatic t_program();
    wr_desc(0, 6'b100110, 11'h010, 1, 7'h05, 14'h0100);
    wr_desc(1, 6'b111100, 11'h7FF, 1, 7'h06, 14'h3FFF);
    wr_desc(2, 6'b100111, 11'h003, 1, 7'h07, 14'h0200);
    wr_desc(3, 6'b100110, 11'h7FF, 1, 7'h05, 14'h0300);
    wr_desc(4, 6'b000110, 11'h7FF, 1, 7'h08, 14'h0000);
    wr_desc(5, 6'b101110, 11'h7FF, 1, 7'h60, 14'h0040);
    ctl_enable = 1'b1; ctl_seg128 = 1'b1;
  endtask

  task automatic t_fine();
    access(24'h0A0A34, 2'd0, 1'b0);
    check("R4 R6 R2 translate slot0", got_pa, 24'h010A34);
    check("R4 no fault", got_f, 0);
    access(24'hC01234, 2'd0, 1'b0);
    check("R4 slot5 fine", got_pa, 24'h005234);
    access(24'h0C0123, 2'd2, 1'b1);
    check("R9 sup fetch ok", {got_f, got_pa}, {1'b0, 24'h400023});
  endtask

  task automatic t_length();
    access(24'h0A10FF, 2'd1, 1'b0);
    check("R8 at length", {got_f, got_pa}, {1'b0, 24'h0110FF});
    access(24'h0A1100, 2'd1, 1'b0);
    check("R8 R12 over length", {got_f, got_pa}, {1'b1, 24'h0});
    check("R8 R10 stat", stat, 8'h23);
    clear_stat();
  endtask

  task automatic t_access();
    access(24'h0C0123, 2'd1, 1'b1);
    check("R9 write to read-only", got_f, 1);
    check("R9 R10 stat", stat, 8'h1E);
    clear_stat();
    access(24'h0C0123, 2'd0, 1'b0);
    check("R9 user on sup seg", got_f, 1);
    check("R9 user stat", stat, 8'h1E);
    clear_stat();
    access(24'h0E0380, 2'd3, 1'b0);
    check("R9 stack access ok", {got_f, got_pa}, {1'b0, 24'h020380});
    access(24'h0E0380, 2'd2, 1'b0);
    check("R10 fetch in stack seg", stat, 8'h53);
    clear_stat();
  endtask

  task automatic t_absent();
    access(24'h100000, 2'd0, 1'b1);
    check("R7 present bit clear", {got_f, stat}, {1'b1, 8'h80});
    clear_stat();
    access(24'h400000, 2'd0, 1'b1);
    check("R7 no match", {got_f, stat}, {1'b1, 8'h80});
    access(24'h0A1100, 2'd0, 1'b0);
    check("R11 first fault kept", stat, 8'h80);
    clear_stat();
    check("R11 cleared", stat, 0);
  endtask

  task automatic t_coarse();
    ctl_seg128 = 1'b0;
    access(24'hC12345, 2'd0, 1'b0);
    check("R5 coarse slot5", {got_f, got_pa}, {1'b0, 24'h016345});
    access(24'h000100, 2'd0, 1'b0);
    check("R5 R6 coarse lowest slot", {got_f, got_pa}, {1'b0, 24'h010100});
    access(24'hDFFFFF, 2'd0, 1'b0);
    check("R5 R8 coarse length", {got_f, stat}, {1'b1, 8'h27});
    clear_stat();
    ctl_seg128 = 1'b1;
  endtask

  task automatic t_backpressure();
    rsp_ready = 1'b0;
    access(24'h0A0A34, 2'd0, 1'b0);
    check("R13 response up", got_v, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R13 held", {rsp_valid, rsp_paddr}, {1'b1, 24'h010A34});
      check("R13 req_ready low", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R13 drained", rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_program();
    t_fine();
    t_length();
    t_access();
    t_absent();
    t_coarse();
    t_backpressure();
    repeat (2) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule